// File: doc/BRIEF.md
# Timer Interrupt Status Controller

This block gathers interrupt and error status for a small group of general-purpose timers. Each timer delivers a one-cycle period-event pulse and a one-cycle overflow/error pulse. For every timer the block keeps a sticky interrupt latch and a sticky overflow flag. Software reads both flags through a single status word and clears them by writing ones. A per-timer configuration enable decides whether the interrupt latch may set at all. The overflow flag is never gated.

The status word also carries per-timer start and stop command bits. A single write can therefore clear flags and change which timers run, all in the same cycle. Each timer's interrupt request is its latch ANDed with an external mask bit, delayed by a register stage. A masked timer can still be polled through its latch. The timer counters, the processor core and interrupt vectoring sit outside this block.

The status word is `4*N_TMR` bits wide and has four fields of `N_TMR` bits. With the default of four timers, the latches are at [3:0], the overflow flags at [7:4], start/run at [11:8] and stop at [15:12].

Top module: `tmr_irq_stat`

## Requirements
- R1: While reset is asserted and right after it, every latch bit, overflow bit and run state reads 0 and every `irq_req` bit is 0.
- R2: A cycle with `tmr_evt[i]=1` and `cfg_irqen[i]=1` sets latch bit i (status bit i), and it reads 1 from the next cycle on. It stays 1 until software clears it.
- R3: A cycle with `tmr_err[i]=1` sets overflow bit i (status bit N_TMR+i) from the next cycle on, whatever `cfg_irqen` holds. It stays set until cleared.
- R4: While `cfg_irqen[i]=0`, an event on timer i leaves latch bit i at 0.
- R5: A write with a one in a latch or overflow bit position clears that bit on the next cycle. A zero in that position leaves the bit unchanged.
- R6: When a clearing write and a setting pulse hit the same bit in the same cycle, the bit reads 1 afterwards.
- R7: A write with bit 2*N_TMR+i set starts timer i, and a write with bit 3*N_TMR+i set stops it. Both commands take effect on the next cycle. Status bits [3*N_TMR-1:2*N_TMR] read the run states (mirrored on `tmr_run`), and the stop field always reads 0.
- R8: When start and stop are both written as one for the same timer, the timer ends up stopped.
- R9: One write can clear latch and overflow bits and start and stop timers together. All effects appear in the same next cycle.
- R10: `irq_req[i]` equals latch bit i ANDed with `irq_mask[i]` as they stood one cycle earlier. With the mask bit at 0, the latch still sets and reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the status word |
| bus_wdata | input | 4*N_TMR | Write data: clear ones, start and stop commands |
| bus_rdata | output | 4*N_TMR | Status word read value |
| tmr_evt | input | N_TMR | Per-timer period-event pulses |
| tmr_err | input | N_TMR | Per-timer overflow/error pulses |
| cfg_irqen | input | N_TMR | Per-timer latch enable |
| irq_mask | input | N_TMR | Per-timer request mask |
| tmr_run | output | N_TMR | Per-timer run state |
| irq_req | output | N_TMR | Registered per-timer interrupt requests |

## Verification
The properties assume that the event, error, enable, mask and write inputs are synchronous to `clk` and stable around each rising edge. They also assume that every asserted input bit counts as one pulse for that cycle, and that the request check applies only with a single request stage. The bench changes every input on the falling edge only. It draws pulses, write data and masks from a seeded generator, so that event pulses, clearing writes and start/stop collisions on the same bit happen often within the legal input space.

// File: rtl/tmr_irq_stat_pkg.sv
package tmr_irq_stat_pkg;
   // Field order inside the status word, lowest field first.
   typedef enum int {
      FLD_LATCH = 0,
      FLD_OVF   = 1,
      FLD_RUN   = 2,
      FLD_STOP  = 3
   } stat_fld_e;

   localparam int NUM_FLDS = 4;

   function automatic int fld_lo(stat_fld_e f, int n);
      return int'(f) * n;
   endfunction
endpackage

// File: rtl/tsc_sticky_bank.sv
// Bank of set-dominant sticky flags with write-one-to-clear.
module tsc_sticky_bank #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q_o[b] <= 1'b0;
         else if (set_i[b])
            q_o[b] <= 1'b1;
         else if (clr_i[b])
            q_o[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/tsc_run_ctrl.sv
// Per-timer run state driven by start/stop command pulses; stop dominates.
module tsc_run_ctrl #(
   parameter int N_TMR = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [N_TMR-1:0] start_i,
   input  logic [N_TMR-1:0] stop_i,
   output logic [N_TMR-1:0] run_o
);
   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            run_o[t] <= 1'b0;
         else if (wr_i && stop_i[t])
            run_o[t] <= 1'b0;
         else if (wr_i && start_i[t])
            run_o[t] <= 1'b1;
      end
   end
endmodule

// File: rtl/tsc_irq_out.sv
// Masked request with a configurable number of register stages.
module tsc_irq_out #(
   parameter int N_TMR  = 4,
   parameter int STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_TMR-1:0] latch_i,
   input  logic [N_TMR-1:0] mask_i,
   output logic [N_TMR-1:0] req_o
);
   logic [N_TMR-1:0] pipe_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[0] <= '0;
            else        pipe_q[0] <= latch_i & mask_i;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[s] <= '0;
            else        pipe_q[s] <= pipe_q[s-1];
         end
      end
   end

   assign req_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tmr_irq_stat.sv
module tmr_irq_stat
   import tmr_irq_stat_pkg::*;
#(
   parameter int N_TMR      = 4,
   parameter int IRQ_STAGES = 1,
   localparam int DW        = NUM_FLDS * N_TMR
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [N_TMR-1:0] tmr_evt,
   input  logic [N_TMR-1:0] tmr_err,
   input  logic [N_TMR-1:0] cfg_irqen,
   input  logic [N_TMR-1:0] irq_mask,
   output logic [N_TMR-1:0] tmr_run,
   output logic [N_TMR-1:0] irq_req
);
   localparam int LO_LATCH = fld_lo(FLD_LATCH, N_TMR);
   localparam int LO_OVF   = fld_lo(FLD_OVF,   N_TMR);
   localparam int LO_RUN   = fld_lo(FLD_RUN,   N_TMR);
   localparam int LO_STOP  = fld_lo(FLD_STOP,  N_TMR);

   if (N_TMR < 1 || N_TMR > 16) begin : g_bad_ntmr
      $error("tmr_irq_stat: N_TMR must lie in 1..16");
   end
   if (IRQ_STAGES < 1 || IRQ_STAGES > 4) begin : g_bad_stages
      $error("tmr_irq_stat: IRQ_STAGES must lie in 1..4");
   end

   logic [N_TMR-1:0] latch_q, ovf_q;
   logic [N_TMR-1:0] latch_clr, ovf_clr;
   logic [N_TMR-1:0] latch_set;

   assign latch_clr = bus_wr ? bus_wdata[LO_LATCH +: N_TMR] : '0;
   assign ovf_clr   = bus_wr ? bus_wdata[LO_OVF   +: N_TMR] : '0;
   assign latch_set = tmr_evt & cfg_irqen;

   tsc_sticky_bank #(.WIDTH(N_TMR)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (latch_set),
      .clr_i (latch_clr),
      .q_o   (latch_q)
   );

   tsc_sticky_bank #(.WIDTH(N_TMR)) u_ovf (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (tmr_err),
      .clr_i (ovf_clr),
      .q_o   (ovf_q)
   );

   tsc_run_ctrl #(.N_TMR(N_TMR)) u_run (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (bus_wr),
      .start_i (bus_wdata[LO_RUN  +: N_TMR]),
      .stop_i  (bus_wdata[LO_STOP +: N_TMR]),
      .run_o   (tmr_run)
   );

   tsc_irq_out #(.N_TMR(N_TMR), .STAGES(IRQ_STAGES)) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .latch_i (latch_q),
      .mask_i  (irq_mask),
      .req_o   (irq_req)
   );

   always_comb begin
      bus_rdata                       = '0;
      bus_rdata[LO_LATCH +: N_TMR]    = latch_q;
      bus_rdata[LO_OVF   +: N_TMR]    = ovf_q;
      bus_rdata[LO_RUN   +: N_TMR]    = tmr_run;
   end
endmodule

// File: rtl/tmr_irq_stat_chk.sv
module tmr_irq_stat_chk #(
   parameter int N_TMR      = 4,
   parameter int IRQ_STAGES = 1,
   localparam int DW        = 4 * N_TMR
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [DW-1:0]    bus_wdata,
   input logic [DW-1:0]    bus_rdata,
   input logic [N_TMR-1:0] tmr_evt,
   input logic [N_TMR-1:0] tmr_err,
   input logic [N_TMR-1:0] cfg_irqen,
   input logic [N_TMR-1:0] irq_mask,
   input logic [N_TMR-1:0] tmr_run,
   input logic [N_TMR-1:0] irq_req
);
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r1: assert (bus_rdata == '0 && irq_req == '0)
            else $error("R1 state not clear in reset");
      end
   end

   p_stop_field_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[3*N_TMR +: N_TMR] == '0);

   p_run_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[2*N_TMR +: N_TMR] == tmr_run);

   for (genvar i = 0; i < N_TMR; i++) begin : g_bit
      p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rdata[i] && !(bus_wr && bus_wdata[i])) |=> bus_rdata[i]);

      p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
         tmr_err[i] |=> bus_rdata[N_TMR+i]);

      p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!bus_rdata[i] && !(tmr_evt[i] && cfg_irqen[i])) |=> !bus_rdata[i]);

      p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_wdata[i] && !(tmr_evt[i] && cfg_irqen[i])) |=> !bus_rdata[i]);

      p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (tmr_evt[i] && cfg_irqen[i]) |=> bus_rdata[i]);

      p_stop_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_wdata[3*N_TMR+i]) |=> !tmr_run[i]);

      p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_wdata[2*N_TMR+i] && !bus_wdata[3*N_TMR+i]) |=> tmr_run[i]);

      if (IRQ_STAGES == 1) begin : g_req
         p_req_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_req[i] == $past(bus_rdata[i] && irq_mask[i])));
      end
   end
endmodule

bind tmr_irq_stat tmr_irq_stat_chk #(.N_TMR(N_TMR), .IRQ_STAGES(IRQ_STAGES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .tmr_evt   (tmr_evt),
   .tmr_err   (tmr_err),
   .cfg_irqen (cfg_irqen),
   .irq_mask  (irq_mask),
   .tmr_run   (tmr_run),
   .irq_req   (irq_req)
);

// File: tb/tmr_irq_stat_test.sv
module tmr_irq_stat_test;
   localparam int N  = 4;
   localparam int W  = 4 * N;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         bus_wr;
   logic [W-1:0] bus_wdata;
   logic [W-1:0] bus_rdata;
   logic [N-1:0] tmr_evt, tmr_err, cfg_irqen, irq_mask, tmr_run, irq_req;

   always #4 clk = ~clk;   // 125 MHz

   tmr_irq_stat #(.N_TMR(N), .IRQ_STAGES(1)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .tmr_evt(tmr_evt), .tmr_err(tmr_err),
      .cfg_irqen(cfg_irqen), .irq_mask(irq_mask), .tmr_run(tmr_run),
      .irq_req(irq_req)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   logic [N-1:0] m_lat, m_ovf, m_run, m_req;

   function automatic logic [N-1:0] next_sticky(logic [N-1:0] old,
                                                 logic [N-1:0] clr,
                                                 logic [N-1:0] set);
      return (old & ~clr) | set;
   endfunction

   function automatic logic [N-1:0] next_run(logic [N-1:0] old, logic wr,
                                              logic [N-1:0] go, logic [N-1:0] halt);
      return wr ? ((old | go) & ~halt) : old;
   endfunction

   function automatic logic [W-1:0] status_word(logic [N-1:0] lat,
                                                  logic [N-1:0] ovf,
                                                  logic [N-1:0] run);
      return {{N{1'b0}}, run, ovf, lat};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Advance one clock, update the model from the inputs seen at the edge.
   task automatic step();
      logic [N-1:0] clr_l, clr_o, req_n;
      @(posedge clk);
      #1;
      clr_l = bus_wr ? bus_wdata[0 +: N] : '0;
      clr_o = bus_wr ? bus_wdata[N +: N] : '0;
      req_n = m_lat & irq_mask;
      m_lat = next_sticky(m_lat, clr_l, tmr_evt & cfg_irqen);
      m_ovf = next_sticky(m_ovf, clr_o, tmr_err);
      m_run = next_run(m_run, bus_wr, bus_wdata[2*N +: N], bus_wdata[3*N +: N]);
      m_req = req_n;
      @(negedge clk);
      cyc++;
   endtask

   task automatic drive(logic wr, logic [W-1:0] wd, logic [N-1:0] evt, logic [N-1:0] err);
      bus_wr = wr; bus_wdata = wd; tmr_evt = evt; tmr_err = err;
   endtask

   task automatic idle();
      drive(1'b0, '0, '0, '0);
   endtask

   task automatic model_check(string tag);
      chk(tag, 32'(bus_rdata), 32'(status_word(m_lat, m_ovf, m_run)));
      chk(tag, 32'(irq_req), 32'(m_req));
   endtask

   always @(posedge clk) begin
      if (!done && cyc > 100000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; cfg_irqen = '1; irq_mask = '1;
      m_lat = '0; m_ovf = '0; m_run = '0; m_req = '0;
      idle();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status", 32'(bus_rdata), 32'h0);
      chk("R1 req", 32'(irq_req), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", 32'(bus_rdata), 32'h0);

      // R2 event sets latch, stays set; R10 request one cycle later
      drive(1'b0, '0, 4'b0001, '0); step();
      chk("R2 set", 32'(bus_rdata[3:0]), 32'h1);
      idle(); step();
      chk("R2 sticky", 32'(bus_rdata[3:0]), 32'h1);
      chk("R10 req", 32'(irq_req), 32'h1);

      // R4 gated latch, R3 overflow sets regardless of gating
      cfg_irqen = 4'b1101;
      drive(1'b0, '0, 4'b0010, 4'b0010); step();
      chk("R4 gated", 32'(bus_rdata[3:0]), 32'h1);
      chk("R3 ovf", 32'(bus_rdata[7:4]), 32'h2);
      cfg_irqen = '1; idle(); step();

      // R10 masked latch still polls
      irq_mask = 4'b1110;
      drive(1'b0, '0, 4'b0100, '0); step();
      idle(); step();
      chk("R10 masked req", 32'(irq_req), 32'h4);
      chk("R10 poll", 32'(bus_rdata[0]), 32'h1);

      // R5 write-one clears, write-zero keeps
      drive(1'b1, 16'h0021, '0, '0); step();
      chk("R5 clear", 32'(bus_rdata[7:0]), 32'h04);
      drive(1'b1, 16'h0000, '0, '0); step();
      chk("R5 zero keeps", 32'(bus_rdata[7:0]), 32'h04);

      // R6 set beats clear
      drive(1'b1, 16'h0004, 4'b0100, '0); step();
      chk("R6 set wins", 32'(bus_rdata[2]), 32'h1);

      // R7 start/stop and readback
      drive(1'b1, 16'h0300, '0, '0); step();
      chk("R7 start", 32'(tmr_run), 32'h3);
      chk("R7 run field", 32'(bus_rdata[11:8]), 32'h3);
      chk("R7 stop field", 32'(bus_rdata[15:12]), 32'h0);
      drive(1'b1, 16'h1000, '0, '0); step();
      chk("R7 stop", 32'(tmr_run), 32'h2);

      // R8 stop dominates start
      drive(1'b1, 16'h4400, '0, '0); step();
      chk("R8 both on idle timer", 32'(tmr_run), 32'h2);
      drive(1'b1, 16'h2200, '0, '0); step();
      chk("R8 both on running timer", 32'(tmr_run), 32'h0);
      drive(1'b1, 16'h0200, '0, '0); step();

      // R9 combined write
      drive(1'b0, '0, '0, 4'b1000); step();
      drive(1'b1, 16'h2584, '0, '0); step();
      chk("R9 combined", 32'(bus_rdata), 32'h0500);
      idle(); step();
      model_check("R9 model");

      // Random phase: R2 R3 R4 R5 R6 R7 R8 R10 against the model
      for (int k = 0; k < 3000; k++) begin
         logic wr;
         wr = ($urandom % 4) == 0;
         if (($urandom % 16) == 0) cfg_irqen = N'($urandom);
         if (($urandom % 8) == 0)  irq_mask  = N'($urandom);
         drive(wr, W'($urandom), N'($urandom & $urandom), N'($urandom & $urandom & $urandom));
         step();
         model_check("R2/R3/R4/R5/R6/R7/R8/R10 random");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule